// File: doc/BRIEF.md
# Sliding-Window Sequential Fetch Cache

This block sits between a processor's instruction or data read port and a serial flash fetch engine. It keeps a copy of the most recent run of bytes that the engine fetched one after another. The copy is described by a base address and a valid length. A processor read whose address falls inside that window is answered from local storage one clock after the request, and the engine is not asked for anything. Any other read goes to the engine.

A read at the address just past the end of the window continues the current run, and the window is kept. A read at any other address outside the window is a jump: the window restarts empty at the new address, and the engine is told to begin a new burst there. Every byte the engine returns that extends the window is stored. Once the window holds its full depth, each new byte pushes the base forward by one, so the storage always holds the trailing bytes of the run. Storage is a circular buffer indexed by the low address bits. No tags or lines are used.

The controller is a four-state machine. `ST_IDLE` accepts a request. A hit takes the *take-hit* transition to `ST_HIT`. A miss takes the *issue-fetch* transition to `ST_FETCH`, which holds the fetch request until the engine delivers the wanted byte; the *fill-arrives* transition then leads to `ST_DONE`. `ST_HIT` and `ST_DONE` each present one ready cycle and take the *retire* transition back to `ST_IDLE`.

Top module: `fetch_cache_win`

## Requirements
- R1: After reset the window length is zero, `cpu_ready` and `fetch_req` are low, and the first read of any address is treated as a jump.
- R2: A read in `ST_IDLE` whose address satisfies (addr − base) mod 2^ADDR_W < length is a hit. `cpu_ready` is high exactly one cycle after the request, with the stored byte on `cpu_rdata`, and `fetch_req` stays low.
- R3: A read that misses and is not at base + length (or finds an empty window) is a jump. From the next cycle `fetch_req` is high with `fetch_jump` = 1 and `fetch_addr` = the read address, and the window restarts with base = that address and length = 0.
- R4: A read that misses at exactly base + length with a non-zero length is sequential. `fetch_req` rises with `fetch_jump` = 0 and `fetch_addr` = the read address, and the window is kept.
- R5: A fill (`fill_valid` high) whose `fill_addr` equals base + length stores `fill_data` at index `fill_addr` mod DEPTH. If the length is below DEPTH it grows by one, and it never exceeds DEPTH.
- R6: A fill that extends a full window advances the base by one, so the oldest byte stops hitting while the newest DEPTH bytes still hit.
- R7: In `ST_FETCH`, `fetch_req` and `fetch_addr` hold until a fill arrives whose address equals the pending read address. On the next cycle `cpu_ready` is high with that fill's data, and `fetch_req` is low.
- R8: A fill whose address is not base + length leaves the window unchanged.
- R9: `cpu_ready` is a single-cycle pulse, and a `cpu_req` raised while the controller is not in `ST_IDLE` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | One-cycle read request from the processor |
| cpu_addr | input | ADDR_W | Read address |
| cpu_ready | output | 1 | Read data valid, one-cycle pulse |
| cpu_rdata | output | DATA_W | Read data |
| fetch_req | output | 1 | Fetch engine request, held until the wanted byte arrives |
| fetch_jump | output | 1 | 1: start a new burst at fetch_addr; 0: continue the current burst |
| fetch_addr | output | ADDR_W | Address of the byte wanted from the engine |
| fill_valid | input | 1 | Engine delivers a byte |
| fill_addr | input | ADDR_W | Address of the delivered byte |
| fill_data | input | DATA_W | Delivered byte |

## Verification
The bench builds the block with ADDR_W = 12, DEPTH = 8 and DATA_W = 8. The small depth lets a few reads fill the window and then slide its base, so the eviction of the oldest byte can be checked without long runs. The 12-bit address lets a run cross from 0xFFF to 0x000, which tests the modular hit comparison and the circular indexing across the address wrap.

// File: rtl/fcw_pkg.sv
package fcw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIT   = 2'd1,
        ST_FETCH = 2'd2,
        ST_DONE  = 2'd3
    } fcw_state_e;
endpackage

// File: rtl/fcw_window.sv
module fcw_window #(
    parameter int ADDR_W = 17,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic              lk_seq,
    input  logic              restart,
    input  logic [ADDR_W-1:0] restart_addr,
    input  logic              app_valid,
    input  logic [ADDR_W-1:0] app_addr,
    output logic              app_ok,
    output logic [ADDR_W-1:0] win_base,
    output logic [$clog2(DEPTH):0] win_len
);
    localparam int LEN_W = $clog2(DEPTH) + 1;
    localparam logic [LEN_W-1:0] FULL = LEN_W'(DEPTH);

    logic [ADDR_W-1:0] len_ext;
    logic [ADDR_W-1:0] tail;
    logic [ADDR_W-1:0] offs;

    // distance from the base, taken modulo the address space
    always_comb begin
        len_ext = {{(ADDR_W-LEN_W){1'b0}}, win_len};
        tail    = win_base + len_ext;
        offs    = lk_addr - win_base;
        lk_hit  = offs < len_ext;
        lk_seq  = (win_len != '0) && (lk_addr == tail);
        app_ok  = app_valid && !restart && (app_addr == tail);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_base <= '0;
            win_len  <= '0;
        end else if (restart) begin
            win_base <= restart_addr;
            win_len  <= '0;
        end else if (app_ok) begin
            if (win_len == FULL)
                win_base <= win_base + ADDR_W'(1);
            else
                win_len <= win_len + LEN_W'(1);
        end
    end
endmodule

// File: rtl/fcw_store.sv
module fcw_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    always_comb rd_data = mem[rd_idx];
endmodule

// File: rtl/fcw_fsm.sv
module fcw_fsm
    import fcw_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              lk_hit,
    input  logic              lk_seq,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    output fcw_state_e        state,
    output logic              take_hit,
    output logic              restart,
    output logic              fill_match,
    output logic              cpu_ready,
    output logic              fetch_req,
    output logic              fetch_jump,
    output logic [ADDR_W-1:0] fetch_addr
);
    fcw_state_e        nxt;
    logic              accept;
    logic [ADDR_W-1:0] pend_addr;
    logic              pend_jump;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req && lk_hit)
                    nxt = ST_HIT;       // take-hit
                else if (cpu_req)
                    nxt = ST_FETCH;     // issue-fetch
            end
            ST_HIT:   nxt = ST_IDLE;    // retire
            ST_FETCH: begin
                if (fill_match)
                    nxt = ST_DONE;      // fill-arrives
            end
            ST_DONE:  nxt = ST_IDLE;    // retire
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_jump <= 1'b0;
        end else if (accept && !lk_hit) begin
            pend_addr <= cpu_addr;
            pend_jump <= !lk_seq;
        end
    end

    always_comb begin
        accept     = (state == ST_IDLE) && cpu_req;
        take_hit   = accept && lk_hit;
        restart    = accept && !lk_hit && !lk_seq;
        fill_match = (state == ST_FETCH) && fill_valid && (fill_addr == pend_addr);
        cpu_ready  = (state == ST_HIT) || (state == ST_DONE);
        fetch_req  = (state == ST_FETCH);
        fetch_jump = fetch_req && pend_jump;
        fetch_addr = pend_addr;
    end
endmodule

// File: rtl/fetch_cache_win.sv
module fetch_cache_win
    import fcw_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              fetch_req,
    output logic              fetch_jump,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int IDX_W = $clog2(DEPTH);

    fcw_state_e        state;
    logic              lk_hit, lk_seq, app_ok;
    logic              take_hit, restart, fill_match;
    logic [ADDR_W-1:0] win_base;
    logic [IDX_W:0]    win_len;
    logic [DATA_W-1:0] hit_data;

    fcw_window #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_win (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_addr      (cpu_addr),
        .lk_hit       (lk_hit),
        .lk_seq       (lk_seq),
        .restart      (restart),
        .restart_addr (cpu_addr),
        .app_valid    (fill_valid),
        .app_addr     (fill_addr),
        .app_ok       (app_ok),
        .win_base     (win_base),
        .win_len      (win_len)
    );

    fcw_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_en   (app_ok),
        .wr_idx  (fill_addr[IDX_W-1:0]),
        .wr_data (fill_data),
        .rd_idx  (cpu_addr[IDX_W-1:0]),
        .rd_data (hit_data)
    );

    fcw_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_addr   (cpu_addr),
        .lk_hit     (lk_hit),
        .lk_seq     (lk_seq),
        .fill_valid (fill_valid),
        .fill_addr  (fill_addr),
        .state      (state),
        .take_hit   (take_hit),
        .restart    (restart),
        .fill_match (fill_match),
        .cpu_ready  (cpu_ready),
        .fetch_req  (fetch_req),
        .fetch_jump (fetch_jump),
        .fetch_addr (fetch_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            cpu_rdata <= '0;
        else if (take_hit)
            cpu_rdata <= hit_data;
        else if (fill_match)
            cpu_rdata <= fill_data;
    end
endmodule

// File: rtl/fcw_checker.sv
module fcw_checker
    import fcw_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DEPTH  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input fcw_state_e        state,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              lk_hit,
    input logic              lk_seq,
    input logic              app_ok,
    input logic              fill_match,
    input logic              cpu_ready,
    input logic              fetch_req,
    input logic              fetch_jump,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [ADDR_W-1:0] win_base,
    input logic [$clog2(DEPTH):0] win_len
);
    localparam int LEN_W = $clog2(DEPTH) + 1;
    localparam logic [LEN_W-1:0] FULL = LEN_W'(DEPTH);

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        win_len <= FULL) else $error("length above depth"); // R5

    AST_HIT_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cpu_req && lk_hit) |=> (cpu_ready && !fetch_req)); // R2

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cpu_req && !lk_hit && !lk_seq) |=>
        (fetch_req && fetch_jump && fetch_addr == $past(cpu_addr)
         && win_base == $past(cpu_addr) && win_len == '0)); // R3

    AST_SEQ_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cpu_req && !lk_hit && lk_seq) |=>
        (fetch_req && !fetch_jump && fetch_addr == $past(cpu_addr))); // R4

    AST_SLIDE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (app_ok && win_len == FULL) |=>
        (win_len == FULL && win_base == $past(win_base) + ADDR_W'(1))); // R6

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fill_match) |=> (fetch_req && $stable(fetch_addr))); // R7

    AST_FILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_match |=> (cpu_ready && !fetch_req)); // R7

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R9
endmodule

bind fetch_cache_win fcw_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .cpu_req    (cpu_req),
    .cpu_addr   (cpu_addr),
    .lk_hit     (lk_hit),
    .lk_seq     (lk_seq),
    .app_ok     (app_ok),
    .fill_match (fill_match),
    .cpu_ready  (cpu_ready),
    .fetch_req  (fetch_req),
    .fetch_jump (fetch_jump),
    .fetch_addr (fetch_addr),
    .win_base   (win_base),
    .win_len    (win_len)
);

// File: tb/tb_fetch_cache_win.sv
module tb_fetch_cache_win;
    localparam int AW = 12;
    localparam int DP = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          fetch_req;
    logic          fetch_jump;
    logic [AW-1:0] fetch_addr;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference window, kept from the requirements
    int mbase = 0;
    int mlen  = 0;

    always #5 clk = ~clk;

    fetch_cache_win #(.ADDR_W(AW), .DEPTH(DP), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .fetch_req(fetch_req), .fetch_jump(fetch_jump), .fetch_addr(fetch_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data)
    );

    function automatic logic [DW-1:0] dat(input int a);
        return DW'((a * 7 + 3) ^ (a >> 8));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int kind_of(input int a);
        int offs = (a - mbase) & ((1 << AW) - 1);
        if (offs < mlen) return 0;
        if (mlen != 0 && a == ((mbase + mlen) & ((1 << AW) - 1))) return 1;
        return 2;
    endfunction

    function automatic void model_append();
        if (mlen == DP) mbase = (mbase + 1) & ((1 << AW) - 1);
        else mlen++;
    endfunction

    // one read; the engine answers after 'lag' extra cycles
    task automatic do_read(input int a, input string tag, input int lag);
        int k = kind_of(a);
        string kt = (k == 0) ? "R2" : (k == 1) ? "R4" : "R3";
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = AW'(a);
        @(negedge clk);
        cpu_req = 1'b0;
        if (k == 0) begin
            chk(cpu_ready === 1'b1, {kt, " ", tag, " ready"}, cpu_ready, 1);
            chk(cpu_rdata === dat(a), {kt, " ", tag, " data"}, cpu_rdata, dat(a));
            chk(fetch_req === 1'b0, {kt, " ", tag, " no fetch"}, fetch_req, 0);
        end else begin
            chk(fetch_req === 1'b1, {kt, " ", tag, " fetch_req"}, fetch_req, 1);
            chk(fetch_addr === AW'(a), {kt, " ", tag, " fetch_addr"}, fetch_addr, a);
            chk(fetch_jump === (k == 2), {kt, " ", tag, " fetch_jump"}, fetch_jump, (k == 2));
            if (k == 2) begin mbase = a; mlen = 0; end
            for (int i = 0; i < lag; i++) begin
                @(negedge clk);
                chk(fetch_req === 1'b1 && fetch_addr === AW'(a), {"R7 ", tag, " hold"}, fetch_addr, a);
            end
            fill_valid = 1'b1; fill_addr = AW'(a); fill_data = dat(a);
            @(negedge clk);
            fill_valid = 1'b0;
            model_append();
            chk(cpu_ready === 1'b1, {"R7 ", tag, " ready"}, cpu_ready, 1);
            chk(cpu_rdata === dat(a), {"R7 ", tag, " data"}, cpu_rdata, dat(a));
            chk(fetch_req === 1'b0, {"R7 ", tag, " fetch drop"}, fetch_req, 0);
        end
        @(negedge clk);
        chk(cpu_ready === 1'b0, {"R9 ", tag, " pulse"}, cpu_ready, 0);
    endtask

    task automatic t_reset();
        chk(cpu_ready === 1'b0, "R1 ready after reset", cpu_ready, 0);
        chk(fetch_req === 1'b0, "R1 fetch_req after reset", fetch_req, 0);
        chk(kind_of(32'h100) == 2, "R1 model empty", kind_of(32'h100), 2);
        do_read(32'h100, "R1 first read jumps", 0);
    endtask

    task automatic t_fill_and_hit();
        for (int a = 32'h101; a <= 32'h105; a++) do_read(a, "R5 run", 0);
        do_read(32'h100, "R5 first byte", 0);
        do_read(32'h103, "R5 middle", 0);
        do_read(32'h105, "R5 last", 0);
        do_read(32'h106, "R4 edge of partial window", 1);
    endtask

    task automatic t_slide();
        do_read(32'h107, "R6 fill to full", 0);
        do_read(32'h108, "R6 slide one", 0);
        do_read(32'h109, "R6 slide two", 0);
        do_read(32'h102, "R6 oldest kept", 0);
        do_read(32'h109, "R6 newest", 0);
        chk(kind_of(32'h101) == 2, "R6 model evicted", kind_of(32'h101), 2);
        do_read(32'h101, "R6 evicted byte", 0);
    endtask

    task automatic t_stray_fill();
        // window is base 0x101 length 1, tail 0x102
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = AW'(32'h300); fill_data = 8'hEE;
        @(negedge clk);
        fill_addr = AW'(32'h105);
        @(negedge clk);
        fill_valid = 1'b0;
        chk(cpu_ready === 1'b0 && fetch_req === 1'b0, "R8 stray fill quiet", cpu_ready, 0);
        do_read(32'h102, "R8 window unchanged", 0);
    endtask

    task automatic t_busy_req();
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = AW'(32'h400);
        @(negedge clk);
        cpu_addr = AW'(32'h500);          // held request while fetching
        @(negedge clk);
        cpu_req = 1'b0;
        chk(fetch_req === 1'b1 && fetch_addr === AW'(32'h400), "R9 busy request ignored", fetch_addr, 32'h400);
        fill_valid = 1'b1; fill_addr = AW'(32'h400); fill_data = dat(32'h400);
        @(negedge clk);
        fill_valid = 1'b0;
        chk(cpu_rdata === dat(32'h400), "R9 original answered", cpu_rdata, dat(32'h400));
        @(negedge clk);
        chk(cpu_ready === 1'b0, "R9 single pulse", cpu_ready, 0);
        mbase = 32'h400; mlen = 1;
        do_read(32'h500, "R9 later jump", 0);
    endtask

    task automatic t_wrap();
        do_read(32'hFFE, "R3 near top", 0);
        do_read(32'hFFF, "R5 wrap run", 0);
        do_read(32'h000, "R5 wrap run", 0);
        do_read(32'h001, "R5 wrap run", 2);
        do_read(32'hFFF, "R2 across wrap", 0);
        do_read(32'h000, "R2 across wrap", 0);
        do_read(32'hFFD, "R3 below base", 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_and_hit();
        t_slide();
        t_stray_fill();
        t_busy_req();
        t_wrap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule